// File: doc/BRIEF.md
# Synchronized Sampling Hit Counter

This block is one level of a flash time-to-digital converter built from sampling offsets. Every cycle of the reference clock is one trial. At the reference edge the block captures a precomputed sample bit, which is one when the data edge came before the reference edge and zero otherwise. The captured bit then passes through two more flip-flops in series, so that a metastable value is unlikely to reach the counter. The last stage of this three-stage chain enables a saturating counter. Over a measurement window, that counter totals the trials in which the data edge arrived first.

A window opens when `win_en` is raised after a clear. It admits one trial per reference edge until `win_en` falls or the trial limit is reached. The limit is the counter's full range minus one (2^CNT_W - 1). When `win_en` falls, the trials still in the chain keep being counted while it drains. After that the window is complete. Software-free readout works through `read_req`: each request copies the running count and the completion flag into the output registers. A clear empties the chain and starts a new measurement.

Top module: `sampling_hit_counter`

## Requirements
- R1: After reset or after a cycle with `clr` high, the chain and the counter are empty. A read then returns `hit_count` = 0 and `count_valid` = 0 until a new window has run.
- R2: A trial is admitted only at a clock edge where `win_en` is 1, the window has not been closed, and fewer than WINDOW_TRIALS trials have been admitted. An admitted `sample_bit` of 1 counts as a hit, and a non-admitted sample counts as nothing.
- R3: A hit admitted at edge k is in the counter after edge k+3. A read taken at edge k+3 does not include it, and a read at edge k+4 does.
- R4: The counter advances by exactly one for each admitted 1 and is unchanged by an admitted 0.
- R5: Once WINDOW_TRIALS trials have been admitted, further samples are ignored even while `win_en` stays 1.
- R6: Let f be the first edge at which `win_en` is seen 0 in an open window. A read at edge f+2 or earlier returns `count_valid` = 0. A read at edge f+3 or later returns `count_valid` = 1 with the final count.
- R7: A completed window ignores `win_en` and `sample_bit` until the next clear, and its count and valid flag do not change.
- R8: The counter saturates at 2^CNT_W - 1 and does not wrap.
- R9: `hit_count` and `count_valid` change only at an edge where `read_req` or `clr` is 1.
- R10: A clear during an open window discards the hits still in the chain. A window opened after the clear counts from zero.
- R11: A read during an open window returns the running count with `count_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one trial per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of chain, window state, counter and outputs |
| win_en | input | 1 | Window enable; high admits trials |
| sample_bit | input | 1 | Sample at the reference edge, 1 when data came first |
| read_req | input | 1 | Copy running count and completion flag to the outputs |
| hit_count | output | CNT_W | Registered count returned by the last read |
| count_valid | output | 1 | Registered: window was complete at the last read |

## Verification
The bench builds two copies side by side with the same stimulus. The first uses CNT_W = 6 with the default window of 63 trials. With it, a full window, the trial limit and the samples beyond that limit can be reached in a few hundred cycles instead of a million. The second uses CNT_W = 4 with WINDOW_TRIALS = 20, which lets a window hold more hits than the counter can represent, so saturation can be observed. It also moves the trial limit to a point where a counter that wraps or ignores the limit gives a different value from the first copy.

// File: rtl/shc_pkg.sv
package shc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_OPEN  = 2'd1,
    PH_DRAIN = 2'd2,
    PH_DONE  = 2'd3
  } win_phase_e;
endpackage

// File: rtl/shc_capture_chain.sv
// Sampling register followed by synchronizing stages; the tail enables counting.
module shc_capture_chain #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic sample_in,
  input  logic admit,
  output logic tail
);
  logic [DEPTH-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst || clr) stg_q[0] <= 1'b0;
    else            stg_q[0] <= admit & sample_in;
  end

  genvar gi;
  generate
    for (gi = 1; gi < DEPTH; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst || clr) stg_q[gi] <= 1'b0;
        else            stg_q[gi] <= stg_q[gi-1];
      end
    end
  endgenerate

  assign tail = stg_q[DEPTH-1];
endmodule

// File: rtl/shc_window_ctrl.sv
// Window phase tracking, trial admission and drain timing.
module shc_window_ctrl
  import shc_pkg::*;
#(
  parameter int WINDOW_TRIALS = 1048575,
  parameter int CHAIN_DEPTH   = 3,
  localparam int TRIAL_W      = $clog2(WINDOW_TRIALS + 1),
  localparam int DRAIN_W      = $clog2(CHAIN_DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               win_en,
  output logic               admit,
  output win_phase_e         phase,
  output logic [TRIAL_W-1:0] trials
);
  localparam logic [TRIAL_W-1:0] TRIAL_LIMIT = TRIAL_W'(WINDOW_TRIALS);
  localparam logic [DRAIN_W-1:0] DRAIN_LAST  = DRAIN_W'(CHAIN_DEPTH - 2);

  win_phase_e         phase_q;
  logic [TRIAL_W-1:0] trials_q;
  logic [DRAIN_W-1:0] drain_q;
  logic               accepting;

  assign accepting = (phase_q == PH_IDLE) || (phase_q == PH_OPEN);
  assign admit     = win_en && accepting && (trials_q < TRIAL_LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_q  <= PH_IDLE;
      trials_q <= '0;
      drain_q  <= '0;
    end else begin
      if (admit) trials_q <= trials_q + 1'b1;
      unique case (phase_q)
        PH_IDLE: if (win_en) phase_q <= PH_OPEN;
        PH_OPEN: if (!win_en) begin
          phase_q <= PH_DRAIN;
          drain_q <= '0;
        end
        PH_DRAIN: begin
          if (drain_q == DRAIN_LAST) phase_q <= PH_DONE;
          else                       drain_q <= drain_q + 1'b1;
        end
        PH_DONE: phase_q <= PH_DONE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase  = phase_q;
  assign trials = trials_q;
endmodule

// File: rtl/shc_hit_accum.sv
// Saturating hit counter enabled by the chain tail.
module shc_hit_accum #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)                   cnt_q <= '0;
    else if (hit && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/sampling_hit_counter.sv
module sampling_hit_counter
  import shc_pkg::*;
#(
  parameter int CNT_W         = 20,
  parameter int CHAIN_DEPTH   = 3,
  parameter int WINDOW_TRIALS = (1 << CNT_W) - 1,
  localparam int TRIAL_W      = $clog2(WINDOW_TRIALS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             win_en,
  input  logic             sample_bit,
  input  logic             read_req,
  output logic [CNT_W-1:0] hit_count,
  output logic             count_valid
);
  logic               admit;
  logic               chain_tail;
  win_phase_e         phase;
  logic [TRIAL_W-1:0] trials_q;
  logic [CNT_W-1:0]   acc_q;
  logic [CNT_W-1:0]   hit_count_q;
  logic               count_valid_q;

  shc_window_ctrl #(
    .WINDOW_TRIALS(WINDOW_TRIALS),
    .CHAIN_DEPTH  (CHAIN_DEPTH)
  ) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .win_en(win_en),
    .admit (admit),
    .phase (phase),
    .trials(trials_q)
  );

  shc_capture_chain #(
    .DEPTH(CHAIN_DEPTH)
  ) chain_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .sample_in(sample_bit),
    .admit    (admit),
    .tail     (chain_tail)
  );

  shc_hit_accum #(
    .CNT_W(CNT_W)
  ) accum_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .hit  (chain_tail),
    .count(acc_q)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hit_count_q   <= '0;
      count_valid_q <= 1'b0;
    end else if (read_req) begin
      hit_count_q   <= acc_q;
      count_valid_q <= (phase == PH_DONE);
    end
  end

  assign hit_count   = hit_count_q;
  assign count_valid = count_valid_q;
endmodule

// File: rtl/shc_checker.sv
module shc_checker #(
  parameter int CNT_W         = 20,
  parameter int WINDOW_TRIALS = (1 << CNT_W) - 1,
  localparam int TRIAL_W      = $clog2(WINDOW_TRIALS + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               clr,
  input logic               read_req,
  input logic               count_valid,
  input logic [CNT_W-1:0]   hit_count,
  input logic [CNT_W-1:0]   acc_q,
  input logic               chain_tail,
  input logic [TRIAL_W-1:0] trials_q
);
  localparam logic [CNT_W-1:0]   CNT_MAX     = {CNT_W{1'b1}};
  localparam logic [TRIAL_W-1:0] TRIAL_LIMIT = TRIAL_W'(WINDOW_TRIALS);

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (acc_q == '0 && hit_count == '0 && !count_valid)); // R1
  AST_TAIL_GATES_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && !$past(chain_tail)) |-> (acc_q == $past(acc_q))); // R3
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> (acc_q == $past(acc_q) || acc_q == $past(acc_q) + 1'b1)); // R4
  AST_TRIAL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    trials_q <= TRIAL_LIMIT); // R5
  AST_VALID_ON_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(count_valid) |-> $past(read_req)); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr) && $past(acc_q) == CNT_MAX) |-> (acc_q == CNT_MAX)); // R8
  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(read_req) && !$past(clr)) |-> ($stable(hit_count) && $stable(count_valid))); // R9
endmodule

bind sampling_hit_counter shc_checker #(
  .CNT_W        (CNT_W),
  .WINDOW_TRIALS(WINDOW_TRIALS)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .clr        (clr),
  .read_req   (read_req),
  .count_valid(count_valid),
  .hit_count  (hit_count),
  .acc_q      (acc_q),
  .chain_tail (chain_tail),
  .trials_q   (trials_q)
);

// File: tb/sampling_hit_counter_tb_top.sv
module sampling_hit_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic win_en = 1'b0;
  logic sample_bit = 1'b0;
  logic read_req = 1'b0;
  logic [5:0] hit_a;
  logic       val_a;
  logic [3:0] hit_b;
  logic       val_b;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic pend = 1'b0;

  typedef struct {
    int    exp_a;
    int    exp_b;
    bit    exp_v;
    string tag;
  } item_t;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sampling_hit_counter #(.CNT_W(6)) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .win_en(win_en), .sample_bit(sample_bit),
    .read_req(read_req), .hit_count(hit_a), .count_valid(val_a)
  );

  sampling_hit_counter #(.CNT_W(4), .WINDOW_TRIALS(20)) dut_sat_i (
    .clk(clk), .rst(rst), .clr(clr), .win_en(win_en), .sample_bit(sample_bit),
    .read_req(read_req), .hit_count(hit_b), .count_valid(val_b)
  );

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: a read at an edge is compared at the following falling edge.
  always @(posedge clk) pend <= read_req;
  always @(negedge clk) begin
    if (pend) begin
      if (sbq.size() == 0) begin
        chk("scoreboard underflow", 1, 0);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk({it.tag, " count A"}, int'(hit_a), it.exp_a);
        chk({it.tag, " count B"}, int'(hit_b), it.exp_b);
        chk({it.tag, " valid A"}, int'(val_a), int'(it.exp_v));
        chk({it.tag, " valid B"}, int'(val_b), int'(it.exp_v));
      end
    end
  end

  task automatic step(bit w, bit s, bit r, bit c);
    win_en = w; sample_bit = s; read_req = r; clr = c;
    @(negedge clk);
  endtask

  task automatic rd(bit w, bit s, int ea, int eb, bit ev, string tag);
    item_t it;
    it.exp_a = ea; it.exp_b = eb; it.exp_v = ev; it.tag = tag;
    sbq.push_back(it);
    step(w, s, 1'b1, 1'b0);
  endtask

  task automatic do_clear();
    step(1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic close_window();
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [9:0] pat;
    pat = 10'b1011001110;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(0, 0, 0, 0, 0, "R1 after reset");

    // R2: samples with win_en low are not admitted
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0);
    rd(0, 0, 0, 0, 0, "R2 idle samples ignored");

    // R3 / R11 / R6: latency, running read, drain timing
    do_clear();
    step(1, 1, 0, 0);                       // edge k
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    rd(1, 0, 0, 0, 0, "R3 read at k+3");    // not yet counted
    rd(1, 0, 1, 1, 0, "R3 R11 read at k+4");
    step(0, 0, 0, 0);                       // edge f
    step(0, 0, 0, 0);
    rd(0, 0, 1, 1, 0, "R6 read at f+2");
    rd(0, 0, 1, 1, 1, "R6 read at f+3");

    // R7: completed window ignores further trials
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
    rd(0, 0, 1, 1, 1, "R7 done window frozen");

    // R4 / R9: mixed pattern, outputs hold without a read
    do_clear();
    for (int i = 9; i >= 0; i--) step(1, pat[i], 0, 0);
    close_window();
    chk("R9 hold count A", int'(hit_a), 0);
    chk("R9 hold valid A", int'(val_a), 0);
    rd(0, 0, 6, 6, 1, "R4 pattern count");

    // R5: ones after the trial limit are ignored
    do_clear();
    for (int i = 0; i < 63; i++) step(1, 0, 0, 0);
    for (int i = 0; i < 7; i++) step(1, 1, 0, 0);
    close_window();
    rd(0, 0, 0, 0, 1, "R5 beyond limit");

    do_clear();
    for (int i = 0; i < 18; i++) step(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0);
    close_window();
    rd(0, 0, 5, 2, 1, "R5 limit at 20 trials");

    // R8: saturation
    do_clear();
    for (int i = 0; i < 25; i++) step(1, 1, 0, 0);
    close_window();
    rd(0, 0, 25, 15, 1, "R8 saturation");

    // R10 / R1: clear discards hits in the chain
    do_clear();
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    do_clear();
    close_window();
    rd(0, 0, 0, 0, 0, "R10 R1 clear mid window");
    step(1, 1, 0, 0);
    close_window();
    rd(0, 0, 1, 1, 1, "R10 new window after clear");

    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("scoreboard drained", sbq.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule